// File: doc/BRIEF.md
# Stream-to-Memory Burst Writer

This block takes a stream of data words and stores it in main memory through the write half of an AXI4 port, using the address, write-data and write-response channels. Software first selects the block on a narrow configuration port by sending its port number. It then sends a start address and the number of words to store. The block splits the transfer into INCR bursts of fixed length. After each burst the target address moves forward by one burst's worth of bytes. Once every word is written and every write response has come back, it raises a done flag.

The stream input has no handshake. A word is taken on every cycle that its valid line is high. The ready output only asks the producer to stop, and the producer may still deliver a bounded number of words after ready falls. A skid FIFO inside the block holds those late words, and ready falls early enough that the FIFO cannot overflow. All transactions are treated as error-free and in order, so both transaction IDs stay at zero and the response code is not examined. The start address needs only data-word alignment. The word count must be a whole number of bursts.

Top module: `stream_burst_writer`

## Requirements
- R1: Configuration is three words on `cfgValid`/`cfgData`, accepted only while no transfer is running. The first word is the port number, and it must equal `PORT_ID`. The next two words are the start byte address and then the word count. The transfer starts in the cycle after the count word. While the block waits for a port number, a word that is not `PORT_ID` is ignored and starts nothing.
- R2: Every address request carries these fixed values: `awLen` = BURST_LEN-1, `awSize` = log2(DATA_W/8) (3 for 64-bit data) and `awBurst` = 2'b01 (INCR). Both `awId` and `wId` are zero, and `wStrb` is all ones.
- R3: The first burst goes to the programmed start address, which may be any multiple of DATA_W/8. Each later burst goes to the previous address plus (DATA_W/8)*BURST_LEN.
- R4: The data beats carry the stream words in arrival order. Each burst has exactly BURST_LEN beats, and `wLast` is high on the last of them only.
- R5: No data beat of a burst is presented until that burst's address request has been accepted.
- R6: A word is captured on every cycle that `inValid` is high, whatever `inReady` shows. No captured word is lost or duplicated.
- R7: `inReady` is low exactly while the free FIFO slots number STOP_LAT or fewer. It is high otherwise, including after reset.
- R8: `done` is low after reset and goes low in the cycle after a transfer is started. It goes high one cycle after the register update that records the last write response, and it stays high until the next start.
- R9: A raised `awValid` or `wValid` stays raised until accepted. While it waits, `awAddr`, `wData` and `wLast` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration word strobe |
| cfgData | input | ADDR_W | Configuration word: port number, start address or word count |
| inValid | input | 1 | Stream word present |
| inData | input | DATA_W | Stream word |
| inReady | output | 1 | Low asks the producer to stop sending |
| awId | output | ID_W | Write address ID, always zero |
| awAddr | output | ADDR_W | Burst start byte address |
| awLen | output | 8 | Beats per burst minus one |
| awSize | output | 3 | log2 of bytes per beat |
| awBurst | output | 2 | Burst type, INCR |
| awValid | output | 1 | Address request valid |
| awReady | input | 1 | Address request accepted |
| wId | output | ID_W | Write data ID, always zero |
| wData | output | DATA_W | Write beat data |
| wStrb | output | DATA_W/8 | Byte strobes, all set |
| wLast | output | 1 | Final beat of a burst |
| wValid | output | 1 | Write beat valid |
| wReady | input | 1 | Write beat accepted |
| bValid | input | 1 | Write response present |
| bReady | output | 1 | Always accepting responses |
| done | output | 1 | Programmed transfer fully written and acknowledged |

## Verification
The assertions assume that the producer never sends more than STOP_LAT words after it has seen `inReady` low. The bench producer meets this by acting on the value of `inReady` from exactly STOP_LAT cycles earlier. The assertions also assume that the memory side returns a write response only for an address request that was accepted earlier. The bench's memory model returns one response per completed burst, one or more cycles after that burst's last beat. The bench gives a count only while the block is idle and only as a whole number of bursts. It uses start addresses that are word-aligned but not burst-aligned, and it runs every burst count under three back-pressure patterns, one of which prefills the FIFO before configuration.

// File: rtl/stream_burst_writer_pkg.sv
package stream_burst_writer_pkg;

  typedef struct packed {
    logic loadAddr;
    logic stepAddr;
    logic popWord;
  } wr_ctrl_t;

  typedef enum logic [1:0] {
    CFG_ID   = 2'd0,
    CFG_ADDR = 2'd1,
    CFG_CNT  = 2'd2
  } cfg_phase_e;

  typedef enum logic [1:0] {
    RUN_IDLE = 2'd0,
    RUN_ADDR = 2'd1,
    RUN_DATA = 2'd2,
    RUN_RESP = 2'd3
  } run_state_e;

endpackage

// File: rtl/stream_burst_writer_dp.sv
module stream_burst_writer_dp
  import stream_burst_writer_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 32,
  parameter int BURST_LEN = 4,
  parameter int DEPTH     = 8,
  parameter int STOP_LAT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wr_ctrl_t          ctrl,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              fifoEmpty,
  output logic [$clog2(DEPTH+1)-1:0] fifoLevel,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [DATA_W-1:0] headWord
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int STEP  = (DATA_W / 8) * BURST_LEN;

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  level;
  logic              push, pop;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign push = inValid && (level != LVL_W'(DEPTH));
  assign pop  = ctrl.popWord && (level != '0);

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= bumpPtr(wrPtr);
      if (pop)  rdPtr <= bumpPtr(rdPtr);
      case ({push, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstAddr <= '0;
    end else if (ctrl.loadAddr) begin
      burstAddr <= cfgData;
    end else if (ctrl.stepAddr) begin
      burstAddr <= burstAddr + ADDR_W'(STEP);
    end
  end

  assign inReady   = (LVL_W'(DEPTH) - level) > LVL_W'(STOP_LAT);
  assign fifoEmpty = (level == '0);
  assign fifoLevel = level;
  assign headWord  = store[rdPtr];

endmodule

// File: rtl/stream_burst_writer_ctrl.sv
module stream_burst_writer_ctrl
  import stream_burst_writer_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int BURST_LEN = 4,
  parameter logic [ADDR_W-1:0] PORT_ID = ADDR_W'(3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              fifoEmpty,
  input  logic              awReady,
  input  logic              wReady,
  input  logic              bValid,
  output wr_ctrl_t          ctrl,
  output logic              awValid,
  output logic              wValid,
  output logic              wLast,
  output logic              bReady,
  output logic              done
);

  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int BL_SH  = $clog2(BURST_LEN);

  cfg_phase_e        cfgPhase;
  run_state_e        runState;
  logic [CNT_W-1:0]  burstsLeft;
  logic [CNT_W-1:0]  outstanding;
  logic [BEAT_W-1:0] beat;
  logic              idle, startRun, awHs, wHs, lastBeat;
  logic [CNT_W-1:0]  reqBursts;

  assign idle      = (runState == RUN_IDLE);
  assign startRun  = cfgValid && idle && (cfgPhase == CFG_CNT);
  assign reqBursts = CNT_W'(cfgData >> BL_SH);
  assign awValid   = (runState == RUN_ADDR);
  assign wValid    = (runState == RUN_DATA) && !fifoEmpty;
  assign lastBeat  = (beat == BEAT_W'(BURST_LEN - 1));
  assign wLast     = (runState == RUN_DATA) && lastBeat;
  assign awHs      = awValid && awReady;
  assign wHs       = wValid && wReady;
  assign bReady    = 1'b1;

  always_comb begin
    ctrl          = '0;
    ctrl.loadAddr = cfgValid && idle && (cfgPhase == CFG_ADDR);
    ctrl.stepAddr = awHs;
    ctrl.popWord  = wHs;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgPhase <= CFG_ID;
    end else if (cfgValid && idle) begin
      case (cfgPhase)
        CFG_ID:   if (cfgData == PORT_ID) cfgPhase <= CFG_ADDR;
        CFG_ADDR: cfgPhase <= CFG_CNT;
        default:  cfgPhase <= CFG_ID;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= '0;
    end else begin
      case ({awHs, bValid})
        2'b10:   outstanding <= outstanding + CNT_W'(1);
        2'b01:   outstanding <= outstanding - CNT_W'(1);
        default: outstanding <= outstanding;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runState   <= RUN_IDLE;
      burstsLeft <= '0;
      beat       <= '0;
      done       <= 1'b0;
    end else begin
      case (runState)
        RUN_IDLE: begin
          if (startRun) begin
            burstsLeft <= reqBursts;
            done       <= (reqBursts == '0);
            if (reqBursts != '0) runState <= RUN_ADDR;
          end
        end
        RUN_ADDR: begin
          if (awReady) begin
            beat     <= '0;
            runState <= RUN_DATA;
          end
        end
        RUN_DATA: begin
          if (wHs) begin
            beat <= beat + BEAT_W'(1);
            if (lastBeat) begin
              burstsLeft <= burstsLeft - CNT_W'(1);
              runState   <= (burstsLeft == CNT_W'(1)) ? RUN_RESP : RUN_ADDR;
            end
          end
        end
        default: begin
          if (outstanding == '0) begin
            done     <= 1'b1;
            runState <= RUN_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/stream_burst_writer.sv
module stream_burst_writer
  import stream_burst_writer_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 32,
  parameter int ID_W      = 4,
  parameter int CNT_W     = 16,
  parameter int BURST_LEN = 4,
  parameter int DEPTH     = 8,
  parameter int STOP_LAT  = 2,
  parameter logic [ADDR_W-1:0] PORT_ID = ADDR_W'(3)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgValid,
  input  logic [ADDR_W-1:0]   cfgData,
  input  logic                inValid,
  input  logic [DATA_W-1:0]   inData,
  output logic                inReady,
  output logic [ID_W-1:0]     awId,
  output logic [ADDR_W-1:0]   awAddr,
  output logic [7:0]          awLen,
  output logic [2:0]          awSize,
  output logic [1:0]          awBurst,
  output logic                awValid,
  input  logic                awReady,
  output logic [ID_W-1:0]     wId,
  output logic [DATA_W-1:0]   wData,
  output logic [DATA_W/8-1:0] wStrb,
  output logic                wLast,
  output logic                wValid,
  input  logic                wReady,
  input  logic                bValid,
  output logic                bReady,
  output logic                done
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  wr_ctrl_t         ctrl;
  logic             fifoEmpty;
  logic [LVL_W-1:0] fifoLevel;

  stream_burst_writer_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_LEN(BURST_LEN), .PORT_ID(PORT_ID)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgData(cfgData),
    .fifoEmpty(fifoEmpty), .awReady(awReady), .wReady(wReady), .bValid(bValid),
    .ctrl(ctrl), .awValid(awValid), .wValid(wValid), .wLast(wLast),
    .bReady(bReady), .done(done)
  );

  stream_burst_writer_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN),
    .DEPTH(DEPTH), .STOP_LAT(STOP_LAT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cfgData(cfgData),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .fifoEmpty(fifoEmpty), .fifoLevel(fifoLevel),
    .burstAddr(awAddr), .headWord(wData)
  );

  assign awId    = '0;
  assign wId     = '0;
  assign awLen   = 8'(BURST_LEN - 1);
  assign awSize  = 3'($clog2(DATA_W / 8));
  assign awBurst = 2'b01;
  assign wStrb   = '1;

endmodule

// File: rtl/stream_burst_writer_chk.sv
module stream_burst_writer_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       inValid,
  input logic                       awValid,
  input logic                       awReady,
  input logic [ADDR_W-1:0]          awAddr,
  input logic                       wValid,
  input logic                       wReady,
  input logic [DATA_W-1:0]          wData,
  input logic                       wLast,
  input logic                       done,
  input logic [$clog2(DEPTH+1)-1:0] fifoLevel
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [15:0] awCnt, lastCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awCnt   <= '0;
      lastCnt <= '0;
    end else begin
      if (awValid && awReady) awCnt <= awCnt + 16'd1;
      if (wValid && wReady && wLast) lastCnt <= lastCnt + 16'd1;
    end
  end

  assert_aw_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    awValid && !awReady |=> awValid && $stable(awAddr));

  assert_w_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    wValid && !wReady |=> wValid && $stable(wData) && $stable(wLast));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> fifoLevel < LVL_W'(DEPTH));

  assert_addr_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    wValid |-> awCnt > lastCnt);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !awValid && !wValid);

endmodule

bind stream_burst_writer stream_burst_writer_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .awValid(awValid),
  .awReady(awReady), .awAddr(awAddr), .wValid(wValid), .wReady(wReady),
  .wData(wData), .wLast(wLast), .done(done), .fifoLevel(fifoLevel)
);

// File: tb/stream_burst_writer_tb_top.sv
`timescale 1ns/1ps
module stream_burst_writer_tb_top;

  localparam int DATA_W = 64, ADDR_W = 32, ID_W = 4, CNT_W = 16;
  localparam int BL = 4, DEPTH = 8, STOP_LAT = 2;
  localparam logic [31:0] PORT_ID = 32'h3;
  localparam int STEP = (DATA_W / 8) * BL;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgValid = 1'b0, inValid = 1'b0, awReady = 1'b0, wReady = 1'b0, bValid = 1'b0;
  logic [ADDR_W-1:0] cfgData = '0;
  logic [DATA_W-1:0] inData = '0;
  logic inReady, awValid, wLast, wValid, bReady, done;
  logic [ID_W-1:0] awId, wId;
  logic [ADDR_W-1:0] awAddr;
  logic [7:0] awLen;
  logic [2:0] awSize;
  logic [1:0] awBurst;
  logic [DATA_W-1:0] wData;
  logic [DATA_W/8-1:0] wStrb;

  always #4 clk = ~clk;

  stream_burst_writer #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .CNT_W(CNT_W),
    .BURST_LEN(BL), .DEPTH(DEPTH), .STOP_LAT(STOP_LAT), .PORT_ID(PORT_ID)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgData(cfgData),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .awId(awId), .awAddr(awAddr), .awLen(awLen), .awSize(awSize),
    .awBurst(awBurst), .awValid(awValid), .awReady(awReady),
    .wId(wId), .wData(wData), .wStrb(wStrb), .wLast(wLast),
    .wValid(wValid), .wReady(wReady), .bValid(bValid), .bReady(bReady),
    .done(done)
  );

  int tests = 0, failed = 0;
  bit finished = 1'b0, monOn = 1'b0, runActive = 1'b0;
  int cycle = 0, lastBCycle = 0, mode = 0, bDelay = 1, bTimer = 0;
  int expBursts = 0, awIdx = 0, beatIdx = 0, bIdx = 0, pendB = 0;
  int pushCnt = 0, popCnt = 0, srcLeft = 0;
  logic [DATA_W-1:0] srcVal = '0, wordBase = '0, prevWData = '0;
  logic [ADDR_W-1:0] startAddr = '0, prevAwAddr = '0;
  logic [STOP_LAT:0] hist = '0;
  logic [15:0] lfsr = 16'hACE1;
  bit prevAwStall = 1'b0, prevWStall = 1'b0, prevWLast = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory-side model, stream producer and scoreboard
  initial begin
    forever begin
      @(negedge clk);
      cycle++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (monOn) begin
        int occ;
        occ = pushCnt - popCnt;
        check(inReady == ((DEPTH - occ) > STOP_LAT), "R7", "inReady vs free slots",
              longint'(inReady), longint'((DEPTH - occ) > STOP_LAT));
        if (prevAwStall)
          check(awValid && awAddr == prevAwAddr, "R9", "address held while stalled",
                longint'(awAddr), longint'(prevAwAddr));
        if (prevWStall)
          check(wValid && wData == prevWData && wLast == prevWLast, "R9",
                "beat held while stalled", longint'(wData), longint'(prevWData));
        if (!runActive) begin
          check(!awValid && !wValid, "R1", "no traffic while idle",
                longint'({awValid, wValid}), 0);
        end else if (bIdx < expBursts) begin
          check(!done, "R8", "done low during transfer", longint'(done), 0);
        end else if (cycle == lastBCycle + 1) begin
          check(!done, "R8", "done not yet high", longint'(done), 0);
        end else if (cycle == lastBCycle + 2) begin
          check(done, "R8", "done after last response", longint'(done), 1);
          runActive = 1'b0;
        end
      end
      // drive the inputs for the coming edge
      hist = {hist[STOP_LAT-1:0], inReady};
      inValid = monOn && hist[STOP_LAT] && (srcLeft > 0) && (mode != 1 || lfsr[3]);
      inData  = srcVal;
      awReady = (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[0] : (lfsr[1:0] == 2'b00);
      wReady  = (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[2] : (lfsr[5:4] == 2'b00);
      if (bValid) begin
        bValid = 1'b0;
      end else if (pendB > 0) begin
        if (bTimer >= bDelay) begin
          bValid = 1'b1;
          bTimer = 0;
        end else begin
          bTimer++;
        end
      end
      // record the handshakes that happen at the coming edge
      prevAwStall = awValid && !awReady;
      prevAwAddr  = awAddr;
      prevWStall  = wValid && !wReady;
      prevWData   = wData;
      prevWLast   = wLast;
      if (inValid) begin
        pushCnt++;
        srcLeft--;
        srcVal = srcVal + 1;
      end
      if (wValid && wReady) begin
        popCnt++;
        check(wData == wordBase + DATA_W'(beatIdx), "R6", "beat data in order, none lost",
              longint'(wData), longint'(wordBase + DATA_W'(beatIdx)));
        check(wLast == ((beatIdx % BL) == BL - 1), "R4", "wLast position",
              longint'(wLast), longint'((beatIdx % BL) == BL - 1));
        check(awIdx * BL > beatIdx, "R5", "address accepted before data",
              longint'(awIdx), longint'(beatIdx / BL + 1));
        check(beatIdx < expBursts * BL, "R4", "no extra beat",
              longint'(beatIdx), longint'(expBursts * BL));
        if ((beatIdx % BL) == BL - 1) pendB++;
        beatIdx++;
      end
      if (awValid && awReady) begin
        check(awAddr == startAddr + ADDR_W'(awIdx * STEP), "R3", "burst address",
              longint'(awAddr), longint'(startAddr + ADDR_W'(awIdx * STEP)));
        check(awLen == 8'(BL - 1) && awSize == 3'd3 && awBurst == 2'b01, "R2",
              "burst fields", longint'({awLen, awSize, awBurst}),
              longint'({8'(BL - 1), 3'd3, 2'b01}));
        check(awId == '0 && wId == '0 && wStrb == '1 && bReady, "R2",
              "ids zero and full strobes", longint'({awId, wId, wStrb}), longint'(8'hFF));
        awIdx++;
      end
      if (bValid && bReady) begin
        bIdx++;
        pendB--;
        lastBCycle = cycle;
      end
    end
  end

  task automatic sendCfg(input logic [31:0] id, input logic [31:0] addr,
                         input logic [31:0] cnt, input bit arm);
    @(negedge clk);
    cfgValid = 1'b1;
    cfgData  = id;
    @(negedge clk);
    cfgData  = addr;
    @(negedge clk);
    cfgData  = cnt;
    @(posedge clk);
    if (arm) runActive = 1'b1;
    @(negedge clk);
    cfgValid = 1'b0;
    cfgData  = '0;
  endtask

  initial begin
    int burstSet [4];
    burstSet = '{1, 2, 3, 5};
    repeat (4) @(negedge clk);
    check(inReady && !awValid && !wValid && !done, "R7", "reset state",
          longint'({inReady, awValid, wValid, done}), longint'(4'b1000));
    check(!done, "R8", "done low after reset", longint'(done), 0);
    rstN  = 1'b1;
    monOn = 1'b1;
    repeat (3) @(negedge clk);

    // wrong port number followed by two non-matching words: must be ignored (R1)
    sendCfg(PORT_ID + 32'd1, 32'h5, 32'h6, 1'b0);
    repeat (10) @(negedge clk);
    check(!awValid && !done, "R1", "unmatched port ignored",
          longint'({awValid, done}), 0);

    for (int run = 0; run < 12; run++) begin
      int nb;
      nb = burstSet[run % 4];
      mode      = run / 4;
      bDelay    = 1 + mode * 2;
      bTimer    = 0;
      expBursts = nb;
      awIdx     = 0;
      beatIdx   = 0;
      bIdx      = 0;
      startAddr = 32'h2000_0008 + 32'(run) * 32'h0001_0108;
      wordBase  = {32'(run + 1), 32'h0};
      srcVal    = wordBase;
      srcLeft   = nb * BL;
      if (mode == 2) repeat (30) @(negedge clk);   // prefill FIFO before config
      sendCfg(PORT_ID, startAddr, 32'(nb * BL), 1'b1);
      while (runActive) @(negedge clk);
      check(beatIdx == nb * BL, "R4", "beat count of transfer",
            longint'(beatIdx), longint'(nb * BL));
      check(awIdx == nb, "R3", "burst count of transfer", longint'(awIdx), longint'(nb));
      repeat (3) @(negedge clk);
      check(done && !awValid, "R8", "done held while idle", longint'(done), 1);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      failed++;
      $display("FAIL R8 watchdog expired actual=%0h expected=%0h", runActive, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule